// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers up to fifteen interrupt requests from peripherals and turns them into a single prioritised level for a processor. Each source is numbered from 1 to 15, and that number is also its priority. Bit n of every register the block holds belongs to source n, and bit 0 is never used. A rising edge on a request line latches the source into a pending register. Software can also raise a source by writing a one to the force register, or drop it by writing a one to the clear register. A mask register lets a source reach the processor only while its bit is one.

The output is the number of the highest pending source that is not masked, or zero when there is none. A trap handler turns this number into its trap type by adding 0x10. When the processor takes the interrupt it returns the level on an acknowledge input, and the block removes that source from pending. The fixed source assignments are:

- source 1: correctable memory error
- sources 2 and 3: the two serial ports
- sources 4 to 7: external pins
- sources 8 and 9: the two timers
- sources 10 to 15: spare

The register bus is 32 bits wide and byte addressed, and reads are registered. The four registers sit at these byte offsets:

| Offset | Register | Access |
|---|---|---|
| 0x0 | mask | read and write |
| 0x4 | pending | read only |
| 0x8 | force | write only |
| 0xC | clear | write only |

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high at a clock edge, the mask and pending registers and `irq_level` become zero. A read issued after reset returns zero from offsets 0x0 and 0x4.
- R2: A write to offset 0x0 stores bits 15:1 of the write data as the mask. A read of 0x0 returns the stored mask, with bit 0 and bits 31:16 read as zero.
- R3: When `irq_in[n]` is low at one clock edge and high at the next, pending bit n is set at that second edge. A request held high sets pending only once: after the bit is cleared it stays clear until the line falls and rises again.
- R4: A write to offset 0x8 sets pending bit n for each one in write data bits 15:1. Offset 0x8 reads as zero.
- R5: A write to offset 0xC clears pending bit n for each one in write data bits 15:1. Zero bits leave their pending bits unchanged, and offset 0xC reads as zero.
- R6: At each edge `irq_level` takes the highest n for which pending bit n and mask bit n are both one after that same edge, or 0 when there is none. So the level always matches the register contents seen after the edge.
- R7: When `ack_valid` is high at an edge, pending bit `ack_level` is cleared at that edge. An acknowledge with level 0 changes nothing.
- R8: When a set (a request edge or a force bit) and a clear (a clear bit or an acknowledge) hit the same source at the same edge, the bit ends up pending.
- R9: Bit 0 is never pending, whatever `irq_in[0]` or bit 0 of a force write does.
- R10: A read issued at one edge (`bus_sel` high, `bus_wr` low) presents its data on `bus_rdata` after that edge. Offset 0x4 returns the pending register, and writes to 0x4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | Request lines, bit n for source n (bit 0 unused) |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest pending unmasked source, 0 when there is none |

## Verification
The assertions assume that `irq_in` is synchronous to `clk` and is held for at least one full cycle, so that a sampled rise is a real edge. They also assume that a single bus access carries only one write per cycle. The bench changes every input on the falling clock edge and keeps each value stable across the rising edge. It only acknowledges levels in the range 0 to 15, which are all valid source numbers or zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFF_MASK  = 4'h0;
  localparam int unsigned OFF_PEND  = 4'h4;
  localparam int unsigned OFF_FORCE = 4'h8;
  localparam int unsigned OFF_CLEAR = 4'hC;
endpackage

// File: rtl/irqc_regbank.sv
module irqc_regbank
  import irqc_pkg::*;
#(
  parameter int unsigned VEC_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [VEC_W-1:0]  pend_q,
  output logic [VEC_W-1:0]  mask_q,
  output logic [VEC_W-1:0]  mask_d,
  output logic [VEC_W-1:0]  force_vec,
  output logic [VEC_W-1:0]  clear_vec,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [VEC_W-1:0] SRC_BITS = {{(VEC_W-1){1'b1}}, 1'b0};

  logic [VEC_W-1:0] wr_vec;
  logic             wdata_unused;
  logic             wr_en, rd_en;
  logic             hit_mask, hit_pend, hit_force, hit_clear;

  assign wr_vec       = bus_wdata[VEC_W-1:0] & SRC_BITS;
  assign wdata_unused = ^bus_wdata[DATA_W-1:VEC_W];
  assign wr_en        = bus_sel & bus_wr;
  assign rd_en        = bus_sel & ~bus_wr;
  assign hit_mask     = (bus_addr == ADDR_W'(OFF_MASK));
  assign hit_pend     = (bus_addr == ADDR_W'(OFF_PEND));
  assign hit_force    = (bus_addr == ADDR_W'(OFF_FORCE));
  assign hit_clear    = (bus_addr == ADDR_W'(OFF_CLEAR));

  assign mask_d    = (wr_en && hit_mask) ? wr_vec : mask_q;
  assign force_vec = (wr_en && hit_force) ? wr_vec : '0;
  assign clear_vec = (wr_en && hit_clear) ? wr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= '0;
      if (hit_mask) bus_rdata[VEC_W-1:0] <= mask_q;
      if (hit_pend) bus_rdata[VEC_W-1:0] <= pend_q;
    end
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned VEC_W = 16,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] irq_in,
  input  logic [VEC_W-1:0] force_vec,
  input  logic [VEC_W-1:0] clear_vec,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [VEC_W-1:0] pend_q,
  output logic [VEC_W-1:0] pend_d
);
  logic [VEC_W-1:0] req_prev;
  logic [VEC_W-1:0] set_vec;
  logic [VEC_W-1:0] clr_vec;

  assign pend_d[0]  = 1'b0;
  assign set_vec[0] = 1'b0;
  assign clr_vec[0] = 1'b0;

  for (genvar g = 1; g < VEC_W; g++) begin : g_src
    assign set_vec[g] = (irq_in[g] & ~req_prev[g]) | force_vec[g];
    assign clr_vec[g] = clear_vec[g] | (ack_valid && ack_level == LVL_W'(g));
    assign pend_d[g]  = set_vec[g] | (pend_q[g] & ~clr_vec[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= '0;
      pend_q   <= '0;
    end else begin
      req_prev <= irq_in;
      pend_q   <= pend_d;
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned VEC_W = 16,
  parameter int unsigned LVL_W = 4
) (
  input  logic [VEC_W-1:0] active,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (active[i]) level = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NUM_SRC = 15,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LVL_W   = $clog2(NUM_SRC + 1),
  parameter int unsigned VEC_W   = NUM_SRC + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [VEC_W-1:0]  irq_in,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [LVL_W-1:0]  irq_level
);
  logic [VEC_W-1:0] mask_q, mask_d, force_vec, clear_vec;
  logic [VEC_W-1:0] pend_q, pend_d;
  logic [LVL_W-1:0] level_d;

  irqc_regbank #(.VEC_W(VEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
    .mask_q(mask_q), .mask_d(mask_d), .force_vec(force_vec),
    .clear_vec(clear_vec), .bus_rdata(bus_rdata)
  );

  irqc_pending #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .force_vec(force_vec),
    .clear_vec(clear_vec), .ack_valid(ack_valid), .ack_level(ack_level),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  irqc_prio #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_prio (
    .active(pend_d & mask_d),
    .level(level_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
    end else begin
      irq_level <= level_d;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_SRC = 15,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned VEC_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [VEC_W-1:0]  irq_in,
  input logic              ack_valid,
  input logic [LVL_W-1:0]  ack_level,
  input logic [LVL_W-1:0]  irq_level,
  input logic [VEC_W-1:0]  pend_q,
  input logic [VEC_W-1:0]  mask_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && mask_q == '0 && irq_level == '0));

  // R9
  bit0_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0]);

  // R6
  level_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (pend_q[irq_level] && mask_q[irq_level]));

  // R6
  level_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) != '0) |-> (irq_level != '0));

  for (genvar k = 1; k < VEC_W; k++) begin : g_bit
    // R3, R8
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_in[k]) |=> pend_q[k]);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_valid && ack_level == LVL_W'(k) && !$rose(irq_in[k]) &&
       !(bus_sel && bus_wr && bus_addr == ADDR_W'(4'h8) && bus_wdata[k]))
      |=> !pend_q[k]);
  end
endmodule

bind irqc_top irqc_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .LVL_W(LVL_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_in(irq_in),
  .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level),
  .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_level = '0;
  logic [3:0]  irq_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level)
  );

  function automatic logic [3:0] top_src(input logic [15:0] v);
    logic [3:0] r = '0;
    for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ack(input logic [3:0] lv);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = lv;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] p, m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 level", 32'(irq_level), 32'h0);
    bus_read(4'h0, rd); check("R1 mask", rd, 32'h0);
    bus_read(4'h4, rd); check("R1 pend", rd, 32'h0);
    // R2 mask storage
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, rd); check("R2 mask all", rd, 32'h0000_FFFE);
    // R4 / R5 write-only registers read zero
    bus_read(4'h8, rd); check("R4 force reads 0", rd, 32'h0);
    bus_read(4'hC, rd); check("R5 clear reads 0", rd, 32'h0);
    // R3 / R6 / R7 per-source edge, level and acknowledge
    for (int n = 1; n < 16; n++) begin
      @(negedge clk); irq_in[n] = 1'b1;
      @(negedge clk);
      check($sformatf("R6 level src%0d", n), 32'(irq_level), 32'(n));
      bus_read(4'h4, rd); check($sformatf("R3 pend src%0d", n), rd, 32'(1) << n);
      ack(4'(n));
      check($sformatf("R7 ack level src%0d", n), 32'(irq_level), 32'h0);
      repeat (3) @(negedge clk);
      bus_read(4'h4, rd); check($sformatf("R3 held once src%0d", n), rd, 32'h0);
      @(negedge clk); irq_in[n] = 1'b0;
    end
    // R9 bit 0 ignored
    @(negedge clk); irq_in[0] = 1'b1;
    bus_write(4'h8, 32'h0000_0001);
    bus_read(4'h4, rd); check("R9 bit0", rd, 32'h0);
    check("R9 level", 32'(irq_level), 32'h0);
    irq_in[0] = 1'b0;
    // R4 force and R5 partial clear
    bus_write(4'h8, 32'hFFFF_AAAA);
    bus_read(4'h4, rd); check("R4 force", rd, 32'h0000_AAAA);
    bus_write(4'hC, 32'h0000_0002);
    bus_read(4'h4, rd); check("R5 clear one", rd, 32'h0000_AAA8);
    // R7 ack level 0 has no effect
    ack(4'h0);
    bus_read(4'h4, rd); check("R7 ack 0", rd, 32'h0000_AAA8);
    // R10 writes to pending ignored
    bus_write(4'h4, 32'h0000_FFFF);
    bus_read(4'h4, rd); check("R10 pend write ignored", rd, 32'h0000_AAA8);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'h4, rd); check("R5 clear all", rd, 32'h0);
    // R8 edge wins over acknowledge
    @(negedge clk); irq_in[3] = 1'b1; ack_valid = 1'b1; ack_level = 4'd3;
    @(negedge clk); ack_valid = 1'b0;
    bus_read(4'h4, rd); check("R8 edge vs ack", rd, 32'h0000_0008);
    bus_write(4'hC, 32'h0000_0008);
    bus_read(4'h4, rd); check("R3 held after clear", rd, 32'h0);
    @(negedge clk); irq_in[3] = 1'b0;
    // R8 edge wins over clear write
    @(negedge clk); irq_in[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h0000_0008;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(4'h4, rd); check("R8 edge vs clear", rd, 32'h0000_0008);
    // R8 force wins over acknowledge
    @(negedge clk); ack_valid = 1'b1; ack_level = 4'd5;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0000_0020;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; ack_valid = 1'b0;
    bus_read(4'h4, rd); check("R8 force vs ack", rd, 32'h0000_0028);
    irq_in[3] = 1'b0;
    // R6 priority sweep over mask and pending patterns
    for (int it = 0; it < 80; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = (it % 4 == 0) ? 16'hFFFF : lfsr;
      bus_write(4'hC, 32'h0000_FFFF);
      bus_write(4'h0, 32'(m));
      bus_write(4'h8, 32'(p));
      check($sformatf("R6 sweep %0d", it), 32'(irq_level), 32'(top_src(p & m & 16'hFFFE)));
      bus_read(4'h4, rd); check($sformatf("R10 sweep pend %0d", it), rd, 32'(p & 16'hFFFE));
      bus_read(4'h0, rd); check($sformatf("R2 sweep mask %0d", it), rd, 32'(m & 16'hFFFE));
    end
    // R1 reset in the middle of operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 level after reset", 32'(irq_level), 32'h0);
    bus_read(4'h4, rd); check("R1 pend after reset", rd, 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule